// File: doc/BRIEF.md
# Hypervisor guest load permission checker

This block decides whether a hypervisor-issued load of guest memory may go ahead, and if not, which exception it raises. The caller supplies the current privilege mode, the virtualization bit, the user-mode hypervisor-access enable, and the leaf permission bits already found for the two translation stages: the guest's own stage and the hypervisor's stage. It also supplies the read and execute attributes of the physical memory region and the read and execute results of the physical memory protection lookup. It decides nothing about walking tables or fetching data. The caller presents the fetched 32-bit word, and the block returns it zero-extended when the load is allowed.

A mode input selects the execute-permission variant, which is used to emulate instruction fetches. In that variant both translation stages check the execute bit where they would normally check the read bit. The physical region must then grant both read and execute, and protection must also grant both. Every failure is still reported with a load exception code, never a fetch code. Without the variant, every stage and attribute only needs read permission.

Each request is a one-cycle strobe. The decision is registered and appears one cycle later together with a one-cycle done pulse. Between decisions the outputs hold their last values.

Top module: `hvm_load_checker`

## Requirements
- R1: A request strobe on one rising edge makes `done` high for exactly the next cycle, with the decision registered at that edge. Without a request, `done` is low and `allow`, `exc_valid`, `exc_code` and `rd_data` keep their values. After reset, all outputs are zero.
- R2: A request with `virt`=1 raises exception code 22 (virtual instruction), whatever the mode and permissions are. It takes priority over every other check.
- R3: Privilege encoding: 2'b11 machine, 2'b01 supervisor, 2'b00 user, 2'b10 reserved. With `virt`=0, a request in user mode with `hu`=0, or in the reserved mode, raises code 2 (illegal instruction). This takes priority over all memory checks. User mode with `hu`=1, supervisor mode and machine mode pass this check.
- R4: The guest-stage check uses `vs_x` when `exec_mode`=1 and `vs_r` when `exec_mode`=0. If that bit is 0, the block raises code 13 (load page fault).
- R5: The hypervisor-stage check is made only after the guest-stage check passes. It uses `g_x` when `exec_mode`=1 and `g_r` otherwise. If that bit is 0, the block raises code 21 (load guest-page fault).
- R6: After both stages pass, the physical region attributes must grant read. When `exec_mode`=1 they must also grant execute. Otherwise the block raises code 5 (load access fault).
- R7: The protection result is never overridden. It must grant read, and also execute when `exec_mode`=1, or the block raises code 5. An execute-only region (`pmp_x`=1, `pmp_r`=0) therefore faults in the execute variant.
- R8: Each decision has exactly one of `allow` or `exc_valid` high. When allowed, `exc_code` is 0 and `rd_data` is `mem_word` zero-extended to XLEN bits. On an exception, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| priv | input | 2 | Current privilege mode (11 M, 01 S, 00 U, 10 reserved) |
| virt | input | 1 | Virtualization mode bit |
| hu | input | 1 | User-mode hypervisor-access enable |
| exec_mode | input | 1 | Selects the execute-permission variant |
| vs_r | input | 1 | Guest-stage leaf read bit |
| vs_x | input | 1 | Guest-stage leaf execute bit |
| g_r | input | 1 | Hypervisor-stage leaf read bit |
| g_x | input | 1 | Hypervisor-stage leaf execute bit |
| pma_r | input | 1 | Physical region grants read |
| pma_x | input | 1 | Physical region grants execute |
| pmp_r | input | 1 | Protection grants read |
| pmp_x | input | 1 | Protection grants execute |
| mem_word | input | 32 | Fetched 32-bit word |
| done | output | 1 | Decision-valid pulse |
| allow | output | 1 | Load permitted |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 5 | Exception cause code |
| rd_data | output | XLEN | Zero-extended load result |

## Verification
The vector table first walks each stage failing alone, in both variants. This separates a design that checks the read bit from one that checks the execute bit, since each vector sets the two bits to opposite values. Further vectors fail two stages at once, to confirm that the earlier stage's code wins. Vectors with every permission cleared, but a virtualization or mode fault present, show that the mode checks outrank memory checks. Directed tests then cover the reset state, holding of outputs between strobes, back-to-back strobes, and a word with its top bit set, which tells zero extension apart from sign extension.

// File: rtl/hvm_load_checker.sv
module hvm_load_checker #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            hu,
  input  logic            exec_mode,
  input  logic            vs_r,
  input  logic            vs_x,
  input  logic            g_r,
  input  logic            g_x,
  input  logic            pma_r,
  input  logic            pma_x,
  input  logic            pmp_r,
  input  logic            pmp_x,
  input  logic [31:0]     mem_word,
  output logic            done,
  output logic            allow,
  output logic            exc_valid,
  output logic [4:0]      exc_code,
  output logic [XLEN-1:0] rd_data
);
  localparam logic [4:0] C_ILLEGAL = 5'd2;
  localparam logic [4:0] C_ACCESS  = 5'd5;
  localparam logic [4:0] C_PAGE    = 5'd13;
  localparam logic [4:0] C_GPAGE   = 5'd21;
  localparam logic [4:0] C_VIRT    = 5'd22;

  logic       mode_ok, vs_ok, g_ok, pma_ok, pmp_ok;
  logic       n_exc;
  logic [4:0] n_code;

  assign mode_ok = (priv == 2'b11) || (priv == 2'b01) || ((priv == 2'b00) && hu);
  assign vs_ok   = exec_mode ? vs_x : vs_r;
  assign g_ok    = exec_mode ? g_x  : g_r;
  assign pma_ok  = pma_r && (pma_x || !exec_mode);
  assign pmp_ok  = pmp_r && (pmp_x || !exec_mode);

  always_comb begin
    n_exc  = 1'b1;
    n_code = C_ACCESS;
    if (virt)                  n_code = C_VIRT;
    else if (!mode_ok)         n_code = C_ILLEGAL;
    else if (!vs_ok)           n_code = C_PAGE;
    else if (!g_ok)            n_code = C_GPAGE;
    else if (!pma_ok || !pmp_ok) n_code = C_ACCESS;
    else begin
      n_exc  = 1'b0;
      n_code = 5'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      allow     <= 1'b0;
      exc_valid <= 1'b0;
      exc_code  <= 5'd0;
      rd_data   <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        allow     <= !n_exc;
        exc_valid <= n_exc;
        exc_code  <= n_code;
        rd_data   <= n_exc ? '0 : XLEN'(mem_word);
      end
    end
  end
endmodule

module hvm_load_checker_sva #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      priv,
  input logic            virt,
  input logic            hu,
  input logic            exec_mode,
  input logic            vs_x,
  input logic            g_x,
  input logic            pma_r,
  input logic            pma_x,
  input logic            pmp_r,
  input logic [31:0]     mem_word,
  input logic            done,
  input logic            allow,
  input logic            exc_valid,
  input logic [4:0]      exc_code,
  input logic [XLEN-1:0] rd_data
);
  // R1
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done && $stable(allow) && $stable(exc_code) && $stable(rd_data));
  // R2
  virt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && virt |=> exc_valid && exc_code == 5'd22);
  // R3
  user_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !virt && priv == 2'b00 && !hu |=> exc_code == 5'd2);
  // R4
  vs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !virt && priv == 2'b11 && exec_mode && !vs_x |=> exc_code == 5'd13);
  // R7
  pmp_xonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !virt && priv == 2'b11 && exec_mode && vs_x && g_x && pma_r && pma_x && !pmp_r
    |=> exc_code == 5'd5);
  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (allow != exc_valid));
  // R8
  data_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && allow |-> exc_code == 5'd0 && rd_data == XLEN'($past(mem_word)));
  // R8
  data_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc_valid |-> rd_data == '0);
endmodule

bind hvm_load_checker hvm_load_checker_sva #(.XLEN(XLEN)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv(priv), .virt(virt),
  .hu(hu), .exec_mode(exec_mode), .vs_x(vs_x), .g_x(g_x), .pma_r(pma_r),
  .pma_x(pma_x), .pmp_r(pmp_r), .mem_word(mem_word), .done(done),
  .allow(allow), .exc_valid(exc_valid), .exc_code(exc_code), .rd_data(rd_data)
);

// File: tb/tb_hvm_load_checker.sv
`timescale 1ns/1ps
module tb_hvm_load_checker;
  localparam int XLEN = 64;
  localparam int NV = 20;
  // {virt,hu,exec}_{priv}_{vs_r,vs_x,g_r,g_x}_{pma_r,pma_x,pmp_r,pmp_x}_{allow}_{code}
  localparam logic [18:0] VEC [NV] = '{
    19'b000_11_1010_1010_1_00000, // R8 plain read, M
    19'b001_11_1111_1111_1_00000, // R8 exec, M
    19'b001_11_1011_1111_0_01101, // R4 exec, vs_x=0
    19'b000_01_0111_1111_0_01101, // R4 read, vs_r=0
    19'b001_01_0110_1111_0_10101, // R5 exec, g_x=0
    19'b000_11_1001_1111_0_10101, // R5 read, g_r=0
    19'b001_11_0101_1011_0_00101, // R6 exec, pma_x=0
    19'b001_11_0101_0111_0_00101, // R6 exec, pma_r=0
    19'b001_11_0101_1101_0_00101, // R7 exec-only protection
    19'b000_11_1111_1101_0_00101, // R7 read, pmp_r=0
    19'b000_01_1010_1010_1_00000, // R6 R7 read needs no execute
    19'b000_00_1111_1111_0_00010, // R3 U, hu=0
    19'b011_00_1111_1111_1_00000, // R3 U, hu=1 exec
    19'b010_00_0111_1111_0_01101, // R3 R4 U hu=1, vs_r=0
    19'b100_01_1111_1111_0_10110, // R2 virt, all ok
    19'b101_00_0000_0000_0_10110, // R2 virt over everything
    19'b001_00_0000_0000_0_00010, // R3 over memory faults
    19'b010_10_1111_1111_0_00010, // R3 reserved mode
    19'b001_11_1010_1111_0_01101, // R4 R5 vs wins over g
    19'b001_11_0100_0011_0_10101  // R5 R6 g wins over pma
  };

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] priv = 0;
  logic virt = 0, hu = 0, exec_mode = 0, vs_r = 0, vs_x = 0, g_r = 0, g_x = 0;
  logic pma_r = 0, pma_x = 0, pmp_r = 0, pmp_x = 0;
  logic [31:0] mem_word = 0;
  logic done, allow, exc_valid;
  logic [4:0] exc_code;
  logic [XLEN-1:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hvm_load_checker #(.XLEN(XLEN)) dut (.*);

  function automatic string tag_of(input logic [4:0] c);
    case (c)
      5'd22: return "R2";
      5'd2:  return "R3";
      5'd13: return "R4";
      5'd21: return "R5";
      5'd5:  return "R6/R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [18:0] v, input logic [31:0] w);
    {virt, hu, exec_mode, priv, vs_r, vs_x, g_r, g_x, pma_r, pma_x, pmp_r, pmp_x} = v[18:6];
    mem_word = w;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_dec(input logic [18:0] v, input logic [31:0] w);
    string t;
    t = tag_of(v[4:0]);
    check({t, " done"}, XLEN'(done), 1);
    check({t, " allow"}, XLEN'(allow), XLEN'(v[5]));
    check({t, " exc_valid"}, XLEN'(exc_valid), XLEN'(!v[5]));
    check({t, " code"}, XLEN'(exc_code), XLEN'(v[4:0]));
    check({t, " data"}, rd_data, v[5] ? XLEN'(w) : '0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset done", XLEN'(done), 0);
    check("R1 reset allow", XLEN'(allow), 0);
    check("R1 reset exc", XLEN'({exc_valid, exc_code}), 0);
    check("R1 reset data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], 32'h8000_0000 | 32'(i * 32'h0101));
      expect_dec(VEC[i], 32'h8000_0000 | 32'(i * 32'h0101));
      @(negedge clk);
      // R1 outputs hold without a request
      check("R1 idle done", XLEN'(done), 0);
      check("R1 idle code", XLEN'(exc_code), XLEN'(VEC[i][4:0]));
    end

    // R8 zero extension with all upper bits of word set
    apply(VEC[1], 32'hFFFF_FFFF);
    check("R8 zext", rd_data, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk);

    // R1 back-to-back requests
    {virt, hu, exec_mode, priv, vs_r, vs_x, g_r, g_x, pma_r, pma_x, pmp_r, pmp_x} = VEC[2][18:6];
    req_valid = 1;
    @(negedge clk);
    check("R1 b2b first code", XLEN'(exc_code), 13);
    {virt, hu, exec_mode, priv, vs_r, vs_x, g_r, g_x, pma_r, pma_x, pmp_r, pmp_x} = VEC[0][18:6];
    mem_word = 32'h1234_5678;
    @(negedge clk);
    req_valid = 0;
    check("R1 b2b second done", XLEN'(done), 1);
    check("R1 b2b second allow", XLEN'(allow), 1);
    check("R8 b2b data", rd_data, 64'h1234_5678);
    @(negedge clk);
    check("R1 b2b done falls", XLEN'(done), 0);

    // R1 inputs change without a request: outputs hold
    virt = 1; mem_word = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R1 no-req allow hold", XLEN'(allow), 1);
    check("R1 no-req data hold", rd_data, 64'h1234_5678);

    // R1 reset mid-run clears outputs
    rst_n = 0;
    @(negedge clk);
    check("R1 re-reset allow", XLEN'(allow), 0);
    check("R1 re-reset data", rd_data, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule